// File: doc/BRIEF.md
# Prefix Mapper and Low-Address Guard

This block converts a real address into an absolute address by swapping two 8 KiB windows: the window that starts at address zero and the window that starts at a per-processor prefix base. In the same cycle it checks stores against a low-address guard that covers the first 512 bytes of each of the first two 4 KiB pages. When that guard is active it marks any access to those two pages with a write-invalidate flag. A downstream translation cache uses that flag so it never reuses a mapping of a partly guarded page for a later store.

A request is a single-cycle strobe carrying the full real address, an access kind, the prefix base and three control inputs: the guard enable, whether address translation is on, and the private-space bit of the control word for the address space in use. One clock later the block presents a response strobe. The response holds the absolute address of the page, a fault flag, an exception code and the write-invalidate flag. A small two-state machine tracks whether the response registers hold a result produced in the previous cycle. There are two states. ST_IDLE has no response on the outputs. ST_RESP has a response on the outputs. Any cycle with a request moves the machine to ST_RESP, and any cycle without one moves it to ST_IDLE.

Top module: `pfx_guard_unit`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low after a cycle with `req_valid` low. The machine enters ST_RESP on a request and ST_IDLE otherwise.
- R2: When the page start (the address with its low 12 bits cleared) is below 0x2000, `rsp_abs_addr` equals the page start plus `prefix_base`, modulo 2^32.
- R3: When the page start is at least 0x2000, at least `prefix_base`, and below `prefix_base + 0x2000` (computed without wrap), `rsp_abs_addr` equals the page start minus `prefix_base`.
- R4: In every other case `rsp_abs_addr` equals the page start. `rsp_abs_addr` always has its low 12 bits clear.
- R5: The guard is active only when `guard_en` is 1 and either `xlate_on` is 0 or `space_private` is 0. When the guard is inactive, neither `rsp_fault` nor `rsp_wr_inval` is ever set.
- R6: With the guard active, `rsp_wr_inval` is 1 for every access, of any kind, whose page start is 0x0000 or 0x1000. It is 0 for every other page.
- R7: With the guard active, a store (`req_kind` = 2'b01) whose full address is in 0..511 or 4096..4607 sets `rsp_fault`. A store to 512, 4095 or 4608 does not.
- R8: Reads (2'b00), fetches (2'b10) and the spare kind 2'b11 never fault.
- R9: `rsp_code` equals the page start ORed with 0x400 for a store or 0x800 for any other kind. It is ORed with 0x80 as well when `rsp_fault` is set. Code bits 0..11 hold nothing else.
- R10: During reset, `rsp_valid`, `rsp_fault`, `rsp_wr_inval`, `rsp_abs_addr` and `rsp_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Full real address |
| req_kind | input | 2 | 00 read, 01 store, 10 fetch, 11 treated as read |
| prefix_base | input | 32 | Prefix base, expected to be 8 KiB aligned |
| guard_en | input | 1 | Low-address guard enable |
| xlate_on | input | 1 | Address translation is on |
| space_private | input | 1 | Private-space bit of the selected space's control word |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_abs_addr | output | 32 | Page-aligned absolute address |
| rsp_fault | output | 1 | Protection fault |
| rsp_code | output | 32 | Exception code: page start plus fetch/store and guard bits |
| rsp_wr_inval | output | 1 | Do not reuse a cached mapping of this page for stores |

## Verification
The bench targets the byte edges of the guarded ranges: 511 and 512, 4095 and 4096, 4607 and 4608. A design whose range test is off by one, or that checks only the page start, faults on the wrong bytes or misses the guarded ones. The bench also hits the window edges 0x1FFF, 0x2000, the prefix base itself, the last byte of the prefix window, the first byte after it, and a prefix base at the top of the address space. A design that swaps only one way, or lets the window end wrap, returns the wrong page. Reads and fetches to guarded bytes must still raise the write-invalidate flag without faulting. The translation and private-space combinations must switch the guard off only in the one case where both are set.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_SPARE = 2'b11
    } acc_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_t;

    // low-field code values of the exception code
    localparam logic [11:0] CODE_STORE = 12'h400;
    localparam logic [11:0] CODE_LOAD  = 12'h800;
    localparam logic [11:0] CODE_GUARD = 12'h080;
endpackage

// File: rtl/pfx_remap.sv
module pfx_remap #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int WIN_PAGES = 2
) (
    input  logic [ADDR_W-1:0] page_addr,
    input  logic [ADDR_W-1:0] prefix,
    output logic [ADDR_W-1:0] abs_addr
);
    localparam logic [ADDR_W:0] WIN_SPAN = (ADDR_W+1)'(WIN_PAGES) << PAGE_BITS;

    logic [ADDR_W:0] pfx_end;
    logic            in_low;
    logic            in_pfx;

    always_comb begin
        pfx_end = {1'b0, prefix} + WIN_SPAN;
        in_low  = {1'b0, page_addr} < WIN_SPAN;
        in_pfx  = (page_addr >= prefix) && ({1'b0, page_addr} < pfx_end);
        if (in_low)
            abs_addr = page_addr + prefix;
        else if (in_pfx)
            abs_addr = page_addr - prefix;
        else
            abs_addr = page_addr;
    end
endmodule

// File: rtl/pfx_low_guard.sv
module pfx_low_guard
    import pfx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BITS  = 12,
    parameter int WIN_PAGES  = 2,
    parameter int PROT_BYTES = 512
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_kind_t         kind,
    input  logic              guard_en,
    input  logic              xlate_on,
    input  logic              space_private,
    output logic              wr_inval,
    output logic              fault
);
    localparam int PN_W = ADDR_W - PAGE_BITS;

    logic [WIN_PAGES-1:0] page_hit;
    logic [WIN_PAGES-1:0] byte_hit;
    logic                 active;

    for (genvar p = 0; p < WIN_PAGES; p++) begin : g_page
        assign page_hit[p] = (addr[ADDR_W-1:PAGE_BITS] == PN_W'(p));
        assign byte_hit[p] = page_hit[p] &&
                             (addr[PAGE_BITS-1:0] < PAGE_BITS'(PROT_BYTES));
    end

    always_comb begin
        active   = guard_en && (!xlate_on || !space_private);
        wr_inval = active && (|page_hit);
        fault    = active && (|byte_hit) && (kind == ACC_STORE);
    end
endmodule

// File: rtl/pfx_guard_unit.sv
module pfx_guard_unit
    import pfx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BITS  = 12,
    parameter int WIN_PAGES  = 2,
    parameter int PROT_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] prefix_base,
    input  logic              guard_en,
    input  logic              xlate_on,
    input  logic              space_private,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_abs_addr,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_code,
    output logic              rsp_wr_inval
);
    localparam int PN_W = ADDR_W - PAGE_BITS;

    rsp_state_t        state_q, state_d;
    acc_kind_t         kind;
    logic [ADDR_W-1:0] page_addr;
    logic [ADDR_W-1:0] abs_d;
    logic              fault_d;
    logic              inval_d;
    logic [11:0]       low_code;
    logic [ADDR_W-1:0] code_d;

    assign kind      = acc_kind_t'(req_kind);
    assign page_addr = {req_addr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};

    pfx_remap #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WIN_PAGES(WIN_PAGES)
    ) u_remap (
        .page_addr(page_addr),
        .prefix   (prefix_base),
        .abs_addr (abs_d)
    );

    pfx_low_guard #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
        .WIN_PAGES(WIN_PAGES), .PROT_BYTES(PROT_BYTES)
    ) u_guard (
        .addr         (req_addr),
        .kind         (kind),
        .guard_en     (guard_en),
        .xlate_on     (xlate_on),
        .space_private(space_private),
        .wr_inval     (inval_d),
        .fault        (fault_d)
    );

    always_comb begin
        low_code = (kind == ACC_STORE) ? CODE_STORE : CODE_LOAD;
        if (fault_d)
            low_code = low_code | CODE_GUARD;
        code_d = {req_addr[ADDR_W-1:PAGE_BITS], PAGE_BITS'(low_code)};
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_abs_addr <= '0;
            rsp_fault    <= 1'b0;
            rsp_code     <= '0;
            rsp_wr_inval <= 1'b0;
        end else if (req_valid) begin
            rsp_abs_addr <= abs_d;
            rsp_fault    <= fault_d;
            rsp_code     <= code_d;
            rsp_wr_inval <= inval_d;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r4_abs_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_abs_addr[PAGE_BITS-1:0] == '0);
    a_r5_guard_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(guard_en)) |-> (!rsp_fault && !rsp_wr_inval));
    a_r6_fault_marks_page: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> rsp_wr_inval);
    a_r7_fault_is_store: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> ($past(req_kind) == 2'b01));
    a_r9_code_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code[7] == rsp_fault && (rsp_code[10] != rsp_code[11])));
    a_r9_code_page: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_code[ADDR_W-1:PAGE_BITS] == $past(req_addr[ADDR_W-1:PAGE_BITS]));
endmodule

// File: tb/sim_pfx_guard_unit.sv
module sim_pfx_guard_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] prefix_base = '0;
    logic        guard_en = 1'b0;
    logic        xlate_on = 1'b0;
    logic        space_private = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_abs_addr;
    logic        rsp_fault;
    logic [31:0] rsp_code;
    logic        rsp_wr_inval;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pfx_guard_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .prefix_base(prefix_base), .guard_en(guard_en),
        .xlate_on(xlate_on), .space_private(space_private),
        .rsp_valid(rsp_valid), .rsp_abs_addr(rsp_abs_addr), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .rsp_wr_inval(rsp_wr_inval)
    );

    function automatic bit guarded_byte(input logic [31:0] a);
        return (a <= 32'd511) || (a >= 32'd4096 && a <= 32'd4607);
    endfunction

    function automatic bit guard_live(input bit g, input bit x, input bit p);
        return g && (!x || !p);
    endfunction

    function automatic logic [31:0] model_abs(input logic [31:0] a, input logic [31:0] pf);
        logic [31:0] pg = a & 32'hFFFF_F000;
        logic [32:0] hi = {1'b0, pf} + 33'h2000;
        if (pg < 32'h2000) return pg + pf;
        if (pg >= pf && {1'b0, pg} < hi) return pg - pf;
        return pg;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic [31:0] pf,
                          input bit g, input bit x, input bit p);
        logic [31:0] pg, e_abs, e_code;
        bit live, e_fault, e_inval;
        string rtag;
        pg      = a & 32'hFFFF_F000;
        live    = guard_live(g, x, p);
        e_fault = live && (k == 2'b01) && guarded_byte(a);
        e_inval = live && (pg == 32'h0 || pg == 32'h1000);
        e_abs   = model_abs(a, pf);
        e_code  = pg | ((k == 2'b01) ? 32'h400 : 32'h800) | (e_fault ? 32'h80 : 32'h0);
        if (pg < 32'h2000) rtag = "R2";
        else if (pg >= pf && {1'b0, pg} < {1'b0, pf} + 33'h2000) rtag = "R3";
        else rtag = "R4";
        @(negedge clk);
        req_addr = a; req_kind = k; prefix_base = pf;
        guard_en = g; xlate_on = x; space_private = p; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check("R1 valid", {31'b0, rsp_valid}, 32'd1);
        check(rtag, rsp_abs_addr, e_abs);
        check(!live ? "R5 fault" : (k == 2'b01 ? "R7 fault" : "R8 fault"),
              {31'b0, rsp_fault}, {31'b0, e_fault});
        check(!live ? "R5 inval" : "R6 inval", {31'b0, rsp_wr_inval}, {31'b0, e_inval});
        check("R9 code", rsp_code, e_code);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        #7;
        // R10 reset state
        check("R10 valid", {31'b0, rsp_valid}, 32'd0);
        check("R10 abs", rsp_abs_addr, 32'd0);
        check("R10 code", rsp_code, 32'd0);
        check("R10 flags", {30'b0, rsp_fault, rsp_wr_inval}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // directed: guarded byte edges, R7 and R8
        access(32'd511,  2'b01, 32'h0004_0000, 1, 0, 0);
        access(32'd512,  2'b01, 32'h0004_0000, 1, 0, 0);
        access(32'd4095, 2'b01, 32'h0004_0000, 1, 0, 0);
        access(32'd4096, 2'b01, 32'h0004_0000, 1, 0, 0);
        access(32'd4607, 2'b01, 32'h0004_0000, 1, 0, 0);
        access(32'd4608, 2'b01, 32'h0004_0000, 1, 0, 0);
        access(32'd0,    2'b00, 32'h0004_0000, 1, 0, 0);
        access(32'd16,   2'b10, 32'h0004_0000, 1, 0, 0);
        access(32'd16,   2'b11, 32'h0004_0000, 1, 0, 0);
        // R5 combinations
        access(32'd8, 2'b01, 32'h0004_0000, 1, 1, 1);
        access(32'd8, 2'b01, 32'h0004_0000, 1, 1, 0);
        access(32'd8, 2'b01, 32'h0004_0000, 1, 0, 1);
        access(32'd8, 2'b01, 32'h0004_0000, 0, 0, 0);
        // window edges, R2 R3 R4
        access(32'h0000_1FFF, 2'b00, 32'h0004_0000, 0, 0, 0);
        access(32'h0000_2000, 2'b00, 32'h0004_0000, 0, 0, 0);
        access(32'h0004_0000, 2'b00, 32'h0004_0000, 0, 0, 0);
        access(32'h0004_1FFF, 2'b00, 32'h0004_0000, 0, 0, 0);
        access(32'h0004_2000, 2'b00, 32'h0004_0000, 0, 0, 0);
        access(32'h0003_FFFF, 2'b00, 32'h0004_0000, 0, 0, 0);
        access(32'hFFFF_F123, 2'b01, 32'hFFFF_E000, 1, 0, 0);
        access(32'h0000_1004, 2'b00, 32'hFFFF_E000, 1, 0, 0);
        access(32'h0000_1004, 2'b00, 32'h0000_0000, 1, 0, 0);

        // R1 idle cycle
        @(negedge clk); @(posedge clk); #1;
        check("R1 idle", {31'b0, rsp_valid}, 32'd0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] pf, a;
            int sel;
            pf  = ($urandom() % 4 == 0) ? 32'h0 : ($urandom() & 32'hFFFF_E000);
            sel = $urandom() % 4;
            case (sel)
                0: a = $urandom() % 32'h2000;
                1: a = pf + ($urandom() % 32'h2000);
                2: a = ($urandom() % 2 == 0 ? 32'd0 : 32'd4096) + ($urandom() % 1024);
                default: a = $urandom();
            endcase
            access(a, 2'($urandom()), pf, 1'($urandom()), 1'($urandom()), 1'($urandom()));
        end

        @(negedge clk); @(posedge clk); #1;
        check("R1 idle end", {31'b0, rsp_valid}, 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule